// File: doc/BRIEF.md
# Reconfigurable Test Register (Pattern Generator / Signature Compactor)

This block is a row of W flip-flops that does double duty. In mission operation it is a plain parallel-load register. Two control inputs can also turn the same flip-flops into a serial scan chain, an autonomous pseudo-random pattern generator, or a multiple-input signature compactor. No second set of test flip-flops is needed.

Placing one such register in front of a combinational block and another behind it gives self-test of that block. The upstream register runs as the generator and feeds patterns into the logic. The downstream register runs as the compactor and folds every response into a signature. A register that sits between two blocks compacts for the block ahead of it in one test session and generates for the block behind it in the next. The feedback taps and the generator seed are parameters. The defaults give a maximal-length 8-bit sequence for the polynomial x^8+x^4+x^3+x^2+1.

Top module: `bilbo_reg`

## Requirements
- R1: While `rstN` is low, `regOut` is all zeros and `scanOut` is 0.
- R2: With `ctlHi`=1 and `ctlLo`=1 (load mode), each rising edge copies `parIn` into `regOut`.
- R3: With `ctlHi`=0 and `ctlLo`=0 (scan mode), each rising edge moves bit i-1 into bit i and `scanIn` into bit 0. `parIn` is ignored in this mode.
- R4: `scanOut` always equals the top bit `regOut[W-1]`, so a scan shift presents the old bit W-2 there after the edge.
- R5: With `ctlHi`=1 and `ctlLo`=0 (compaction mode), the next state is the state shifted up one place, with a feedback bit entering bit 0, and the result XORed bitwise with `parIn`. The feedback bit is the XOR of the bits selected by `TAP_MASK`. The default mask is 8'h8E, which selects bits 7, 3, 2 and 1. `scanIn` is ignored in this mode.
- R6: With `ctlHi`=0 and `ctlLo`=1 (generator mode), the first edge in that mode loads `SEED` (default 8'h01). The first edge counts as such after reset or after any cycle spent in another mode.
- R7: On each later edge in generator mode, the register shifts with the feedback bit of R5. Both `parIn` and `scanIn` are ignored.
- R8: With the default mask and seed, generator mode never produces all zeros. It returns to `SEED` for the first time after exactly 255 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlHi | input | 1 | Upper mode-select bit |
| ctlLo | input | 1 | Lower mode-select bit |
| parIn | input | W | Parallel data / response inputs |
| scanIn | input | 1 | Serial input into bit 0 |
| regOut | output | W | Register contents |
| scanOut | output | 1 | Serial output, top bit of the register |

## Verification
The bench targets the first cycle of generator mode. A design that keeps shifting stale state instead of loading the seed can stall at zero or start from the wrong point, and will miss the seed after reset or after the compactor-to-generator role swap. It also drives the top bit through compaction and generator steps and walks the full 255-step cycle. A wrong tap or a feedback bit taken from the wrong end breaks the model sequence, shortens the period or reaches zero. Scan shifting is checked bit by bit at `scanOut`, which exposes a reversed shift direction. Changing `parIn` in generator mode, and a two-register test around a small logic block, show whether the parallel inputs leak into the generator or the compactor loses responses.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  // Mode code is {ctlHi, ctlLo}
  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_GEN  = 2'b01,
    MODE_SIG  = 2'b10,
    MODE_LOAD = 2'b11
  } bilboMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSeed;  // force the generator seed
    logic loadPar;   // copy parallel inputs
    logic shiftEn;   // advance one place
    logic useFb;     // bit 0 takes feedback instead of scanIn
    logic mixPar;    // XOR parallel inputs into the shifted value
  } bilboStrobe_t;

endpackage

// File: rtl/bilbo_ctrl.sv
module bilbo_ctrl
  import bilbo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlHi,
  input  logic         ctlLo,
  output bilboStrobe_t strobe
);

  bilboMode_e mode;
  logic       isGen;
  logic       inGen;   // previous cycle was generator mode

  always_comb mode = bilboMode_e'({ctlHi, ctlLo});
  assign isGen = (mode == MODE_GEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inGen <= 1'b0;
    else       inGen <= isGen;
  end

  always_comb begin
    strobe = '0;
    case (mode)
      MODE_LOAD: strobe.loadPar = 1'b1;
      MODE_SCAN: strobe.shiftEn = 1'b1;
      MODE_SIG: begin
        strobe.shiftEn = 1'b1;
        strobe.useFb   = 1'b1;
        strobe.mixPar  = 1'b1;
      end
      MODE_GEN: begin
        strobe.loadSeed = !inGen;
        strobe.shiftEn  = inGen;
        strobe.useFb    = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/bilbo_dp.sv
module bilbo_dp
  import bilbo_pkg::*;
#(
  parameter int unsigned    W        = 8,
  parameter logic [W-1:0]   TAP_MASK = 8'h8E,
  parameter logic [W-1:0]   SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  bilboStrobe_t strobe,
  input  logic [W-1:0] parIn,
  input  logic         scanIn,
  output logic [W-1:0] q
);

  logic         fbBit;
  logic         injectBit;
  logic [W-1:0] stepVal;

  assign fbBit     = ^(q & TAP_MASK);
  assign injectBit = strobe.useFb ? fbBit : scanIn;

  // One cell per stage: the shifted-in bit, optionally mixed with its response
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stepVal[i] = injectBit ^ (strobe.mixPar & parIn[i]);
    end else begin : g_body
      assign stepVal[i] = q[i-1] ^ (strobe.mixPar & parIn[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                q <= '0;
    else if (strobe.loadSeed) q <= SEED;
    else if (strobe.loadPar)  q <= parIn;
    else if (strobe.shiftEn)  q <= stepVal;
  end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned    W        = 8,
  parameter logic [W-1:0]   TAP_MASK = 8'h8E,
  parameter logic [W-1:0]   SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlHi,
  input  logic         ctlLo,
  input  logic [W-1:0] parIn,
  input  logic         scanIn,
  output logic [W-1:0] regOut,
  output logic         scanOut
);

  localparam int unsigned LAST = W - 1;

  bilboStrobe_t strobe;

  bilbo_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctlHi  (ctlHi),
    .ctlLo  (ctlLo),
    .strobe (strobe)
  );

  bilbo_dp #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .parIn  (parIn),
    .scanIn (scanIn),
    .q      (regOut)
  );

  assign scanOut = regOut[LAST];

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int unsigned    W        = 8,
  parameter logic [W-1:0]   TAP_MASK = 8'h8E,
  parameter logic [W-1:0]   SEED     = 8'h01
) (
  input logic         clk,
  input logic         rstN,
  input logic         ctlHi,
  input logic         ctlLo,
  input logic [W-1:0] parIn,
  input logic         scanIn,
  input logic [W-1:0] regOut,
  input logic         scanOut
);

  logic modeLoad, modeScan, modeSig, modeGen, wasGen;

  assign modeLoad = ctlHi && ctlLo;
  assign modeScan = !ctlHi && !ctlLo;
  assign modeSig  = ctlHi && !ctlLo;
  assign modeGen  = !ctlHi && ctlLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasGen <= 1'b0;
    else       wasGen <= modeGen;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad |=> regOut == $past(parIn));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeScan |=> regOut == {$past(regOut[W-2:0]), $past(scanIn)});

  p_scan_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeScan |=> scanOut == $past(regOut[W-2]));

  p_sig_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeSig |=> regOut ==
      ({$past(regOut[W-2:0]), ^($past(regOut) & TAP_MASK)} ^ $past(parIn)));

  p_seed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeGen && !wasGen) |=> regOut == SEED);

  p_gen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeGen && wasGen) |=> regOut ==
      {$past(regOut[W-2:0]), ^($past(regOut) & TAP_MASK)});

  p_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeGen && wasGen) |-> regOut != '0);

endmodule

bind bilbo_reg bilbo_reg_chk #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctlHi   (ctlHi),
  .ctlLo   (ctlLo),
  .parIn   (parIn),
  .scanIn  (scanIn),
  .regOut  (regOut),
  .scanOut (scanOut)
);

// File: tb/test_bilbo_reg.sv
`timescale 1ns/1ps
module test_bilbo_reg;

  localparam logic [7:0] MASK = 8'h8E;
  localparam logic [7:0] SEEDV = 8'h01;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rstN, ctlHi, ctlLo, scanIn;
  logic [7:0] parIn, regOut;
  logic       scanOut;
  logic       sHi, sLo, sScanOut;
  logic [7:0] sPar, sOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  function automatic logic [7:0] nextGen(input logic [7:0] q);
    return {q[6:0], ^(q & MASK)};
  endfunction

  function automatic logic [7:0] nextSig(input logic [7:0] q, input logic [7:0] p);
    return {q[6:0], ^(q & MASK)} ^ p;
  endfunction

  // small logic block under test in the two-register scenario
  function automatic logic [7:0] combo(input logic [7:0] a);
    return (a + {a[3:0], a[7:4]}) ^ 8'h5A;
  endfunction

  assign sPar = combo(regOut);

  bilbo_reg i_bilbo_reg (
    .clk(clk), .rstN(rstN), .ctlHi(ctlHi), .ctlLo(ctlLo),
    .parIn(parIn), .scanIn(scanIn), .regOut(regOut), .scanOut(scanOut)
  );

  bilbo_reg i_bilbo_reg_sink (
    .clk(clk), .rstN(rstN), .ctlHi(sHi), .ctlLo(sLo),
    .parIn(sPar), .scanIn(1'b0), .regOut(sOut), .scanOut(sScanOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive inputs 5 ns after an edge, then sample 5 ns after the next edge
  task automatic tick(input logic hi, input logic lo, input logic [7:0] p, input logic si);
    ctlHi = hi; ctlLo = lo; parIn = p; scanIn = si;
    @(posedge clk); #5;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    @(posedge clk); #5;
    check("R1 regOut in reset", regOut, 8'h00);
    check("R1 scanOut in reset", {7'b0, scanOut}, 8'h00);
    rstN = 1'b1;
  endtask

  task automatic t_load();
    logic [7:0] vals [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
    foreach (vals[i]) begin
      tick(1'b1, 1'b1, vals[i], 1'b1);
      check("R2 parallel load", regOut, vals[i]);
    end
  endtask

  task automatic t_scan();
    logic [7:0] exp;
    logic [7:0] bits = 8'b1011_0010;
    tick(1'b1, 1'b1, 8'h81, 1'b0);
    exp = 8'h81;
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, 1'b0, 8'hFF, bits[i]);
      exp = {exp[6:0], bits[i]};
      check("R3 scan shift", regOut, exp);
      check("R4 scanOut top bit", {7'b0, scanOut}, {7'b0, exp[7]});
    end
  endtask

  task automatic t_sig();
    logic [7:0] exp;
    logic [7:0] words [6] = '{8'h00, 8'h13, 8'hFF, 8'h80, 8'h5A, 8'h01};
    tick(1'b1, 1'b1, 8'h80, 1'b0);
    exp = 8'h80;
    foreach (words[i]) begin
      tick(1'b1, 1'b0, words[i], 1'b1);
      exp = nextSig(exp, words[i]);
      check("R5 compaction step", regOut, exp);
    end
  endtask

  task automatic t_gen();
    logic [7:0] exp;
    int mism = 0, zeros = 0, first = 0;
    tick(1'b1, 1'b1, 8'h00, 1'b0);
    tick(1'b0, 1'b1, 8'hC3, 1'b1);
    check("R6 seed on entry from load", regOut, SEEDV);
    exp = SEEDV;
    for (int k = 1; k <= 255; k++) begin
      tick(1'b0, 1'b1, 8'(k * 37), ~k[0]);
      exp = nextGen(exp);
      if (regOut !== exp) mism++;
      if (regOut == 8'h00) zeros++;
      if (regOut == SEEDV && first == 0) first = k;
    end
    check("R7 generator sequence mismatches", 8'(mism), 8'd0);
    check("R8 zero states seen", 8'(zeros), 8'd0);
    check("R8 period to seed", 8'(first), 8'd255);
  endtask

  task automatic t_reenter();
    logic [7:0] exp = SEEDV;
    tick(1'b0, 1'b1, 8'hF0, 1'b1);
    exp = nextGen(exp);
    check("R7 generator continues", regOut, exp);
    tick(1'b1, 1'b0, 8'h0F, 1'b0);
    exp = nextSig(exp, 8'h0F);
    check("R5 compaction after generator", regOut, exp);
    tick(1'b0, 1'b1, 8'h55, 1'b0);
    check("R6 seed on re-entry", regOut, SEEDV);
  endtask

  task automatic t_wrapper();
    logic [7:0] gExp = 8'h00, sExp = 8'h00;
    sHi = 1'b1; sLo = 1'b1;
    t_reset();
    sHi = 1'b1; sLo = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick(1'b0, 1'b1, 8'hAA, 1'b0);
      sExp = nextSig(sExp, combo(gExp));
      gExp = (k == 0) ? SEEDV : nextGen(gExp);
    end
    check("R5 signature of block responses", sOut, sExp);
    check("R7 upstream generator state", regOut, gExp);
    sHi = 1'b0; sLo = 1'b1;
    tick(1'b1, 1'b1, 8'h00, 1'b0);
    check("R6 compactor swapped to generator", sOut, SEEDV);
    tick(1'b1, 1'b1, 8'h00, 1'b0);
    check("R7 swapped register steps", sOut, nextGen(SEEDV));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    ctlHi = 1'b1; ctlLo = 1'b1; parIn = 8'h00; scanIn = 1'b0;
    sHi = 1'b1; sLo = 1'b1;
    t_reset();
    t_load();
    t_scan();
    t_sig();
    t_gen();
    t_reenter();
    t_wrapper();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

endmodule